// File: doc/BRIEF.md
# FPGA configuration bitstream loader

This block takes a configuration image for one or more downstream FPGAs, presented by a host as 32-bit words, and hands it on to a configuration sink one word at a time. The host first programs the expected image length in bytes while the loader is idle. It then turns the loader on, either in polled mode or in a mode where a request line paces a DMA engine in bursts of half the buffer. Words are written to a single data address that feeds an internal FIFO. The host can read back the FIFO capacity, the FIFO occupancy, the running byte count and a status word that holds error flags and a configuration-done flag.

An interrupt is raised when the targets report completion after the full byte count has been delivered, or when any error is recorded. Writing the control register with the enable bit clear turns the loader off and drops the interrupt. Writing enable together with reset sends a one-cycle reset pulse to the targets, flushes the buffer and clears all progress state. Registers are read combinationally from a read address port; all writes take effect on the clock edge at which they are presented.

Top module: `cfgload_top`

## Requirements
- R1: After reset every register reads zero except the capacity register at 0x48, which reads DEPTH*4 bytes (32 with the default depth), and irq, cfg_rst, dma_req and snk_valid are low.
- R2: The total byte count at 0x50 takes a written value only while the enable bit (bit 0 of control at 0x40) is clear; writes while enabled leave it unchanged.
- R3: A write to 0x3000 stores the word in the FIFO when it is not full; the occupancy register at 0x4C reports stored words times 4; a write to a full FIFO is dropped and sets status bit 1.
- R4: While enabled, words leave on snk_data in write order, one per cycle in which snk_valid and snk_ready are both high; the current count at 0x54 grows by 4 per word, and snk_valid stays low once the current count reaches the total or while disabled.
- R5: Status bit 18 becomes set one cycle after a cycle in which the loader is enabled, the current count equals the total and tgt_done is high; it stays set until a new enable or a reset pulse.
- R6: Status bits 15:1 hold errors: bit 1 for FIFO overflow and bit 2 for a tgt_err pulse seen while enabled; tgt_err while disabled sets nothing. Status bit 0 mirrors the enable bit.
- R7: irq rises one cycle after completion or any new error while enabled, and falls one cycle after a control write with bit 0 clear.
- R8: A control write with bits 0 and 1 both set drives cfg_rst high for exactly the next cycle and clears the done flag, errors, counters and FIFO contents.
- R9: dma_req is high only when enabled with control bit 2 set, the FIFO has at least DEPTH/2 free words, fewer than total bytes have been accepted since the last enable, and no error or done flag is set.
- R10: Turning enable from 0 to 1 clears the current count, the error flags and the done flag without flushing the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register or FIFO write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 32 | Read data for rd_addr |
| snk_valid | output | 1 | A configuration word is offered to the sink |
| snk_data | output | 32 | Offered configuration word |
| snk_ready | input | 1 | Sink accepts the offered word |
| tgt_done | input | 1 | Targets report configuration complete |
| tgt_err | input | 1 | Targets report a configuration error |
| cfg_rst | output | 1 | One-cycle reset pulse to the targets |
| dma_req | output | 1 | Request for a half-FIFO burst |
| irq | output | 1 | Completion or error interrupt |

## Verification
Every register write, FIFO push and word handoff lands on the rising edge of the cycle in which it is presented, so its effect is readable through the combinational read port in the following low phase; status bit 18 and irq are due one edge after the tgt_done or error cycle, and cfg_rst is high for the single cycle after the control write. The bench drives all inputs on the falling edge and samples outputs one nanosecond later, so each check lands in the half cycle just after the edge that produced the result. The sink model records a word only when valid and ready are both seen in that window, which is the cycle whose next edge moves it.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

   // byte addresses decoded by the register block
   localparam logic [15:0] A_CTRL  = 16'h0040;
   localparam logic [15:0] A_STAT  = 16'h0044;
   localparam logic [15:0] A_FSIZE = 16'h0048;
   localparam logic [15:0] A_FUSED = 16'h004C;
   localparam logic [15:0] A_TOTAL = 16'h0050;
   localparam logic [15:0] A_CUR   = 16'h0054;
   localparam logic [15:0] A_FIFO  = 16'h3000;

   // control bit positions
   localparam int C_EN  = 0;
   localparam int C_RST = 1;
   localparam int C_DMA = 2;

   // status bit positions
   localparam int S_EN   = 0;
   localparam int S_OVF  = 1;
   localparam int S_TERR = 2;
   localparam int S_DONE = 18;

   localparam logic [31:0] ERR_FIELD = 32'h0000_FFFE;

   // internal error vector index
   localparam int E_OVF  = 0;
   localparam int E_TERR = 1;

endpackage

// File: rtl/cfgload_fifo.sv
module cfgload_fifo #(
   parameter int DEPTH = 8,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [31:0]   din,
   input  logic          pop,
   output logic [31:0]   dout,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty
);

   logic [31:0]   mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

endmodule

// File: rtl/cfgload_regs.sv
module cfgload_regs
   import cfgload_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int CW     = 4,
   parameter int DEPTH  = 8,
   parameter bit RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [15:0]      wr_addr,
   input  logic [31:0]      wr_data,
   input  logic [15:0]      rd_addr,
   output logic [31:0]      rd_data,
   output logic             en,
   output logic             dma,
   output logic             start,
   output logic             flush,
   output logic             ctl_off,
   output logic             push,
   output logic             cfg_rst,
   output logic [CNT_W-1:0] total,
   input  logic             done,
   input  logic [1:0]       err,
   input  logic [CW-1:0]    fcnt,
   input  logic [CNT_W-1:0] cur
);

   localparam logic [31:0] FSIZE_BYTES = 32'(DEPTH * 4);

   logic        ctl_wr;
   logic [31:0] stat_w, rd_mux;

   assign ctl_wr  = wr_en && (wr_addr == A_CTRL);
   assign start   = ctl_wr && wr_data[C_EN] && !en;
   assign flush   = ctl_wr && wr_data[C_EN] && wr_data[C_RST];
   assign ctl_off = ctl_wr && !wr_data[C_EN];
   assign push    = wr_en && (wr_addr == A_FIFO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en      <= 1'b0;
         dma     <= 1'b0;
         total   <= '0;
         cfg_rst <= 1'b0;
      end else begin
         cfg_rst <= flush;
         if (ctl_wr) begin
            en  <= wr_data[C_EN];
            dma <= wr_data[C_DMA];
         end
         if (wr_en && (wr_addr == A_TOTAL) && !en)
            total <= wr_data[CNT_W-1:0];
      end
   end

   always_comb begin
      stat_w         = '0;
      stat_w[S_EN]   = en;
      stat_w[S_OVF]  = err[E_OVF];
      stat_w[S_TERR] = err[E_TERR];
      stat_w[S_DONE] = done;
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_mux = {29'b0, dma, 1'b0, en};
         A_STAT:  rd_mux = stat_w;
         A_FSIZE: rd_mux = FSIZE_BYTES;
         A_FUSED: rd_mux = 32'({fcnt, 2'b00});
         A_TOTAL: rd_mux = 32'(total);
         A_CUR:   rd_mux = 32'(cur);
         default: rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rd_data = rd_mux;
      end
   endgenerate

endmodule

// File: rtl/cfgload_seq.sv
module cfgload_seq
   import cfgload_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = 32,
   parameter int CW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dma,
   input  logic             start,
   input  logic             flush,
   input  logic             ctl_off,
   input  logic             push,
   input  logic             fifo_full,
   input  logic             fifo_empty,
   input  logic [CW-1:0]    fifo_cnt,
   input  logic [CNT_W-1:0] total,
   input  logic             snk_ready,
   input  logic             tgt_done,
   input  logic             tgt_err,
   output logic             snk_valid,
   output logic             pop,
   output logic [CNT_W-1:0] cur,
   output logic             done,
   output logic [1:0]       err,
   output logic             irq,
   output logic             dma_req
);

   localparam logic [CW-1:0]    HALF = CW'(DEPTH / 2);
   localparam logic [CNT_W-1:0] BEAT = CNT_W'(4);

   logic             clr, ovf_set, terr_set, done_set;
   logic [CNT_W-1:0] acc;

   assign clr       = start || flush;
   assign snk_valid = en && !fifo_empty && (cur < total);
   assign pop       = snk_valid && snk_ready;
   assign ovf_set   = push && fifo_full;
   assign terr_set  = en && tgt_err;
   assign done_set  = en && !done && (cur == total) && tgt_done;
   assign dma_req   = en && dma && (fifo_cnt <= HALF) && (acc < total)
                      && (err == '0) && !done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur  <= '0;
         acc  <= '0;
         done <= 1'b0;
         err  <= '0;
         irq  <= 1'b0;
      end else if (clr) begin
         cur  <= '0;
         acc  <= '0;
         done <= 1'b0;
         err  <= '0;
         irq  <= 1'b0;
      end else begin
         if (pop)               cur <= cur + BEAT;
         if (push && !fifo_full) acc <= acc + BEAT;
         if (done_set)          done <= 1'b1;
         if (ovf_set)           err[E_OVF]  <= 1'b1;
         if (terr_set)          err[E_TERR] <= 1'b1;
         if (ctl_off)
            irq <= 1'b0;
         else if (done_set || terr_set || (en && ovf_set))
            irq <= 1'b1;
      end
   end

endmodule

// File: rtl/cfgload_top.sv
module cfgload_top
   import cfgload_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 32,
   parameter bit RD_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_addr,
   input  logic [31:0] wr_data,
   input  logic [15:0] rd_addr,
   output logic [31:0] rd_data,
   output logic        snk_valid,
   output logic [31:0] snk_data,
   input  logic        snk_ready,
   input  logic        tgt_done,
   input  logic        tgt_err,
   output logic        cfg_rst,
   output logic        dma_req,
   output logic        irq
);

   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("cfgload_top: DEPTH must be a power of two of at least 2");
      end
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
         $error("cfgload_top: CNT_W must lie in 8..32");
      end
   endgenerate

   logic             en_q, dma_q, start, flush, ctl_off, push, pop;
   logic             fifo_full, fifo_empty, done_q;
   logic [CW-1:0]    fifo_cnt;
   logic [1:0]       err_q;
   logic [CNT_W-1:0] total_q, cur_cnt;

   cfgload_regs #(
      .CNT_W(CNT_W), .CW(CW), .DEPTH(DEPTH), .RD_REG(RD_REG)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .en(en_q), .dma(dma_q), .start(start), .flush(flush),
      .ctl_off(ctl_off), .push(push), .cfg_rst(cfg_rst),
      .total(total_q), .done(done_q), .err(err_q),
      .fcnt(fifo_cnt), .cur(cur_cnt)
   );

   cfgload_fifo #(.DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(push), .din(wr_data),
      .pop(pop), .dout(snk_data),
      .cnt(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
   );

   cfgload_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CW(CW)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .en(en_q), .dma(dma_q), .start(start), .flush(flush),
      .ctl_off(ctl_off), .push(push),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt),
      .total(total_q), .snk_ready(snk_ready),
      .tgt_done(tgt_done), .tgt_err(tgt_err),
      .snk_valid(snk_valid), .pop(pop), .cur(cur_cnt),
      .done(done_q), .err(err_q), .irq(irq), .dma_req(dma_req)
   );

endmodule

// File: rtl/cfgload_chk.sv
module cfgload_chk
   import cfgload_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = 32,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [15:0]      wr_addr,
   input logic             wr_en_bit,
   input logic             cfg_rst,
   input logic             irq,
   input logic             dma_req,
   input logic             snk_valid,
   input logic             snk_ready,
   input logic             en,
   input logic             done,
   input logic             ovf,
   input logic [CW-1:0]    fifo_cnt,
   input logic [CNT_W-1:0] cur
);

   logic ctl_wr, fifo_wr;
   assign ctl_wr  = wr_en && (wr_addr == A_CTRL);
   assign fifo_wr = wr_en && (wr_addr == A_FIFO);

   a_r8_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rst |=> !cfg_rst);

   a_r7_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !wr_en_bit) |=> !irq);

   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && snk_ready && !ctl_wr) |=> (cur == $past(cur) + CNT_W'(4)));

   a_r4_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !snk_valid);

   a_r9_room_for_burst: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (int'(fifo_cnt) <= DEPTH / 2));

   a_r3_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && int'(fifo_cnt) == DEPTH && !ctl_wr) |=> ovf);

   a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ctl_wr) |=> done);

endmodule

bind cfgload_top cfgload_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_en_bit(wr_data[0]), .cfg_rst(cfg_rst), .irq(irq), .dma_req(dma_req),
   .snk_valid(snk_valid), .snk_ready(snk_ready), .en(en_q), .done(done_q),
   .ovf(err_q[0]), .fifo_cnt(fifo_cnt), .cur(cur_cnt)
);

// File: tb/cfgload_top_tb_top.sv
`timescale 1ns/1ps
module cfgload_top_tb_top;

   localparam int DEPTH = 8;
   localparam logic [15:0] A_CTRL = 16'h0040, A_STAT = 16'h0044,
      A_FSIZE = 16'h0048, A_FUSED = 16'h004C, A_TOTAL = 16'h0050,
      A_CUR = 16'h0054, A_FIFO = 16'h3000;
   localparam logic [31:0] ERRM = 32'h0000_FFFE;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data, snk_data;
   logic        snk_valid, snk_ready = 1'b0, tgt_done = 1'b0, tgt_err = 1'b0;
   logic        cfg_rst, dma_req, irq;

   cfgload_top #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
      .tgt_done(tgt_done), .tgt_err(tgt_err), .cfg_rst(cfg_rst),
      .dma_req(dma_req), .irq(irq)
   );

   always #2.5 clk = ~clk;

   int total_n = 0, bad_n = 0;
   bit finished = 1'b0;
   int rdy_mode = 0;
   logic [31:0] rx [0:127];
   int rx_n = 0;

   function automatic logic [31:0] wv(input int i);
      return 32'hA500_0000 ^ (32'(i) * 32'h0103_0507);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total_n++;
      if (act !== exp) begin
         bad_n++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wait_drain();
      logic [31:0] v;
      for (int g = 0; g < 400; g++) begin
         rd(A_FUSED, v);
         if (v == 0) break;
         @(negedge clk);
      end
   endtask

   // sink model: decide ready on the falling edge, record the handoff
   always @(negedge clk) begin
      case (rdy_mode)
         0: snk_ready = 1'b0;
         1: snk_ready = 1'b1;
         default: snk_ready = ~snk_ready;
      endcase
      #1;
      if (snk_valid && snk_ready && rx_n < 128) begin
         rx[rx_n] = snk_data;
         rx_n++;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total_n++; bad_n++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
         $display("  test done: total=%0d bad=%0d", total_n, bad_n);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int base;
      int pushed;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(A_CTRL, v);  chk("R1", "ctrl", v, 0);
      rd(A_STAT, v);  chk("R1", "status", v, 0);
      rd(A_FSIZE, v); chk("R1", "fifo size", v, DEPTH * 4);
      rd(A_FUSED, v); chk("R1", "fifo used", v, 0);
      rd(A_TOTAL, v); chk("R1", "total", v, 0);
      rd(A_CUR, v);   chk("R1", "cur", v, 0);
      chk("R1", "outputs", {28'b0, irq, cfg_rst, dma_req, snk_valid}, 0);

      // R2: total written while disabled, ignored while enabled
      wr(A_TOTAL, 64);
      rd(A_TOTAL, v); chk("R2", "total while off", v, 64);
      wr(A_CTRL, 32'h1);
      wr(A_TOTAL, 4);
      rd(A_TOTAL, v); chk("R2", "total while on", v, 64);
      #1; chk("R9", "no req in polled mode", {31'b0, dma_req}, 0);

      // R3/R4: fill with sink stalled, then drain
      base = rx_n;
      for (int i = 0; i < 8; i++) wr(A_FIFO, wv(i));
      rd(A_FUSED, v); chk("R3", "used after 8 words", v, 32);
      chk("R4", "head valid", {31'b0, snk_valid}, 1);
      chk("R4", "head data", snk_data, wv(0));
      rdy_mode = 2;
      wait_drain();
      chk("R4", "words out", 32'(rx_n - base), 8);
      rd(A_CUR, v); chk("R4", "cur after 8", v, 32);
      for (int i = 0; i < 8; i++) wr(A_FIFO, wv(8 + i));
      wait_drain();
      rd(A_CUR, v); chk("R4", "cur after 16", v, 64);
      chk("R4", "words out total", 32'(rx_n - base), 16);
      for (int i = 0; i < 16; i++)
         if (i < rx_n - base) chk("R4", "word order", rx[base + i], wv(i));
      rd(A_STAT, v); chk("R5", "no done without target", v & 32'h0004_0000, 0);

      // R5/R7: completion
      @(negedge clk); tgt_done = 1'b1;
      @(negedge clk); tgt_done = 1'b0;
      rd(A_STAT, v); chk("R5", "done set", v & 32'h0004_0000, 32'h0004_0000);
      chk("R6", "no error", v & ERRM, 0);
      chk("R7", "irq on done", {31'b0, irq}, 1);
      @(negedge clk);
      rd(A_STAT, v); chk("R5", "done sticky", v & 32'h0004_0000, 32'h0004_0000);
      wr(A_CTRL, 0);
      #1; chk("R7", "irq cleared", {31'b0, irq}, 0);
      rd(A_STAT, v); chk("R5", "done kept when off", v & 32'h0004_0000, 32'h0004_0000);

      // R8: reset pulse
      wr(A_CTRL, 32'h3);
      #1; chk("R8", "cfg_rst high", {31'b0, cfg_rst}, 1);
      @(negedge clk);
      #1; chk("R8", "cfg_rst one cycle", {31'b0, cfg_rst}, 0);
      rd(A_STAT, v); chk("R8", "done cleared", v & 32'h0004_0000, 0);
      rd(A_CUR, v);  chk("R8", "cur cleared", v, 0);
      wr(A_CTRL, 0);

      // R4: drain stops at total
      wr(A_TOTAL, 8);
      wr(A_CTRL, 32'h1);
      rdy_mode = 1;
      base = rx_n;
      for (int i = 0; i < 3; i++) wr(A_FIFO, wv(20 + i));
      repeat (4) @(negedge clk);
      chk("R4", "words stop at total", 32'(rx_n - base), 2);
      rd(A_FUSED, v); chk("R4", "leftover word", v, 4);
      rd(A_CUR, v);   chk("R4", "cur at total", v, 8);
      chk("R4", "valid low at total", {31'b0, snk_valid}, 0);
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h3);
      rd(A_FUSED, v); chk("R8", "flush", v, 0);
      wr(A_CTRL, 0);

      // R3/R6/R7/R10: overflow
      rdy_mode = 0;
      wr(A_CTRL, 32'h1);
      for (int i = 0; i < 9; i++) wr(A_FIFO, wv(30 + i));
      rd(A_FUSED, v); chk("R3", "used when full", v, 32);
      rd(A_STAT, v);  chk("R6", "overflow bit", v & ERRM, 32'h2);
      chk("R7", "irq on overflow", {31'b0, irq}, 1);
      wr(A_CTRL, 0);
      #1; chk("R7", "irq off", {31'b0, irq}, 0);
      rd(A_STAT, v);  chk("R6", "error held when off", v & ERRM, 32'h2);
      wr(A_CTRL, 32'h1);
      rd(A_STAT, v);  chk("R10", "errors cleared on enable", v & ERRM, 0);
      chk("R6", "status bit0 enable", v & 32'h1, 1);
      rd(A_FUSED, v); chk("R10", "fifo kept on enable", v, 32);
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h3);
      rd(A_FUSED, v); chk("R8", "flush full fifo", v, 0);
      wr(A_CTRL, 0);

      // R6: target error
      wr(A_TOTAL, 64);
      wr(A_CTRL, 32'h1);
      @(negedge clk); tgt_err = 1'b1;
      @(negedge clk); tgt_err = 1'b0;
      rd(A_STAT, v); chk("R6", "target error bit", v & ERRM, 32'h4);
      chk("R7", "irq on target error", {31'b0, irq}, 1);
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h3);
      wr(A_CTRL, 0);
      @(negedge clk); tgt_err = 1'b1;
      @(negedge clk); tgt_err = 1'b0;
      rd(A_STAT, v); chk("R6", "target error ignored when off", v & ERRM, 0);
      chk("R7", "no irq when off", {31'b0, irq}, 0);

      // R9: DMA paced bursts
      rdy_mode = 1;
      base = rx_n;
      wr(A_CTRL, 32'h5);
      #1; chk("R9", "req after enable", {31'b0, dma_req}, 1);
      pushed = 0;
      for (int g = 0; g < 500 && pushed < 16; g++) begin
         @(negedge clk);
         #1;
         if (dma_req)
            for (int k = 0; k < DEPTH / 2; k++) begin
               wr(A_FIFO, wv(40 + pushed));
               pushed++;
            end
      end
      #1; chk("R9", "req low after total", {31'b0, dma_req}, 0);
      wait_drain();
      chk("R9", "dma words out", 32'(rx_n - base), 16);
      for (int i = 0; i < 16; i++)
         if (i < rx_n - base) chk("R9", "dma word order", rx[base + i], wv(40 + i));
      rd(A_CUR, v); chk("R9", "dma cur", v, 64);
      wr(A_CTRL, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
   end

endmodule